// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the programming word of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divider select and a 2-bit test selector. The word can be set in two ways. In parallel mode it is taken from static pins. In serial mode it is shifted in over a data, strobe and load pin triple. A fast system clock samples every control pin through a two-stage synchronizer and finds the strobe edges in its own domain. For that reason the strobe must run at no more than a quarter of the system clock rate.

The effective divide, select and test values are registered outputs, and downstream divider logic uses them directly. A test pin is also driven. Its source is picked by the two test bits: a constant low, the serial data pin, the feedback divider output or the synthesized clock. The test pin is held low whenever parallel mode is active.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset, eff_t is 00 and test_out is low, and eff_m and eff_n follow the parallel pins while par_load_n is low.
- R2: While par_load_n is low, eff_m and eff_n equal par_m and par_n, one system clock after the synchronized level is seen.
- R3: After par_load_n goes high, later changes on par_m and par_n have no effect on eff_m or eff_n.
- R4: With par_load_n high and ser_ld low, each rising edge of ser_clk shifts ser_dat into a 14-bit register and leaves the effective outputs unchanged.
- R5: A frame is 14 bits sent first bit first: test bit 1, test bit 0, one ignored bit, select bit 1, select bit 0, then divide bits 8 down to 0.
- R6: While ser_ld is high (and par_load_n high), the effective outputs show the decoded shift register, and they update after each ser_clk rising edge.
- R7: After ser_ld falls, the effective outputs stay latched while more bits are shifted.
- R8: Outside parallel mode, test_out is 0 for eff_t=00, ser_dat for 01, fb_div_in for 10 and synth_clk_in for 11.
- R9: In parallel mode, test_out is low and eff_t keeps its value whatever the test bits hold.
- R10: A serial load replaces values captured from the parallel pins. Returning par_load_n low makes the outputs follow the pins again.
- R11: ser_clk edges while par_load_n is low do not change the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Low selects parallel mode; its rise captures the pins |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divider select (00 /1, 01 /2, 10 /4, 11 /8) |
| ser_clk | input | 1 | Serial strobe; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load; high makes the shift register visible |
| fb_div_in | input | 1 | Feedback divider output for the test selector |
| synth_clk_in | input | 1 | Synthesized clock for the test selector |
| eff_m | output | 9 | Effective feedback divide value |
| eff_n | output | 2 | Effective output divider select |
| eff_t | output | 2 | Effective test selector bits |
| test_out | output | 1 | Test pin |

## Verification
The hardest state to reach from the ports is a shift register that differs from the visible word after strobe edges that had to be ignored. The bench toggles ser_clk with all-ones data while parallel mode is active. It then leaves parallel mode and raises ser_ld without sending any bits, so the exposed register contents show whether any of those edges leaked in. Transparency under a held ser_ld is reached by sending a single extra bit after a full frame, which moves every field by one position in a way the bench predicts.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 2;
    localparam int NULL_W  = 1;
    localparam int FRAME_W = T_W + NULL_W + N_W + M_W;

    // bit offsets inside the shift register after a complete frame
    localparam int M_LSB = 0;
    localparam int N_LSB = M_LSB + M_W;
    localparam int Z_LSB = N_LSB + N_W;
    localparam int T_LSB = Z_LSB + NULL_W;

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [M_W-1:0]     m;
        logic [N_W-1:0]     n;
        logic [T_W-1:0]     t;
        logic               sclk_prev;
    } cfg_state_t;

    function automatic logic [M_W-1:0] frame_m(input logic [FRAME_W-1:0] f);
        return f[M_LSB +: M_W];
    endfunction

    function automatic logic [N_W-1:0] frame_n(input logic [FRAME_W-1:0] f);
        return f[N_LSB +: N_W];
    endfunction

    function automatic logic [T_W-1:0] frame_t(input logic [FRAME_W-1:0] f);
        return f[T_LSB +: T_W];
    endfunction

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[gi] <= '0;
                    else        stg_q[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[gi] <= '0;
                    else        stg_q[gi] <= stg_q[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cfgl_test_sel.sv
module cfgl_test_sel #(
    parameter int SEL_W = 2,
    localparam int SRC_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             force_low,
    input  logic [SRC_N-1:0] src,
    output logic             y
);
    always_comb begin
        if (force_low) y = 1'b0;
        else           y = src[sel];
    end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import cfgl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_ld,
    input  logic           fb_div_in,
    input  logic           synth_clk_in,
    output logic [M_W-1:0] eff_m,
    output logic [N_W-1:0] eff_n,
    output logic [T_W-1:0] eff_t,
    output logic           test_out
);
    localparam int CTL_W = 4;

    logic [CTL_W-1:0] ctl_raw;
    logic [CTL_W-1:0] ctl_lvl;
    logic             sclk_lvl;
    logic             dat_lvl;
    logic             ld_lvl;
    logic             par_mode;
    logic             sclk_rise;

    cfg_state_t st_d, st_q;

    // data and strobe share one synchronizer so they keep their alignment
    assign ctl_raw = {par_load_n, ser_ld, ser_dat, ser_clk};

    cfgl_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_lvl)
    );

    assign sclk_lvl = ctl_lvl[0];
    assign dat_lvl  = ctl_lvl[1];
    assign ld_lvl   = ctl_lvl[2];
    assign par_mode = ~ctl_lvl[3];

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_lvl;
        sclk_rise      = sclk_lvl & ~st_q.sclk_prev;
        if (par_mode) begin
            st_d.m = par_m;
            st_d.n = par_n;
        end else begin
            if (sclk_rise) st_d.sh = {st_q.sh[FRAME_W-2:0], dat_lvl};
            if (ld_lvl) begin
                st_d.m = frame_m(st_d.sh);
                st_d.n = frame_n(st_d.sh);
                st_d.t = frame_t(st_d.sh);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eff_m = st_q.m;
    assign eff_n = st_q.n;
    assign eff_t = st_q.t;

    cfgl_test_sel #(.SEL_W(T_W)) u_tsel (
        .sel       (st_q.t),
        .force_low (par_mode),
        .src       ({synth_clk_in, fb_div_in, ser_dat, 1'b0}),
        .y         (test_out)
    );
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker
    import cfgl_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           par_mode,
    input logic           ld_lvl,
    input logic [M_W-1:0] par_m,
    input logic [N_W-1:0] par_n,
    input logic [M_W-1:0] eff_m,
    input logic [N_W-1:0] eff_n,
    input logic [T_W-1:0] eff_t,
    input logic           test_out
);
    a_r2_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
        par_mode |=> (eff_m == $past(par_m) && eff_n == $past(par_n)));

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode && !ld_lvl) |=> ($stable(eff_m) && $stable(eff_n) && $stable(eff_t)));

    a_r9_test_low_par: assert property (@(posedge clk) disable iff (!rst_n)
        par_mode |-> !test_out);

    a_r9_t_kept_par: assert property (@(posedge clk) disable iff (!rst_n)
        par_mode |=> $stable(eff_t));

    a_r8_sel_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode && eff_t == '0) |-> !test_out);
endmodule

bind synth_cfg_loader cfgl_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .ld_lvl   (ld_lvl),
    .par_m    (par_m),
    .par_n    (par_n),
    .eff_m    (eff_m),
    .eff_n    (eff_n),
    .eff_t    (eff_t),
    .test_out (test_out)
);

// File: tb/synth_cfg_loader_test.sv
module synth_cfg_loader_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load_n = 1'b0;
    logic [8:0] par_m = 9'h019;
    logic [1:0] par_n = 2'b01;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_ld = 1'b0;
    logic       fb_div_in = 1'b0;
    logic       synth_clk_in = 1'b0;
    logic [8:0] eff_m;
    logic [1:0] eff_n;
    logic [1:0] eff_t;
    logic       test_out;

    int checks = 0;
    int errors = 0;
    logic [13:0] mdl_sh = '0;

    always #10 clk = ~clk;

    synth_cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
        .par_n(par_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
        .fb_div_in(fb_div_in), .synth_clk_in(synth_clk_in), .eff_m(eff_m),
        .eff_n(eff_n), .eff_t(eff_t), .test_out(test_out)
    );

    // {t[1:0], fb, synth, dat, expected}
    localparam logic [5:0] VEC [8] = '{
        6'b00_1_1_1_0, 6'b00_0_0_0_0, 6'b01_0_0_1_1, 6'b01_1_1_0_0,
        6'b10_1_0_0_1, 6'b10_0_1_1_0, 6'b11_0_1_0_1, 6'b11_1_0_1_0
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic track);
        ser_dat = b;
        ser_clk = 1'b0;
        tick(4);
        ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        if (track) mdl_sh = {mdl_sh[12:0], b};
    endtask

    task automatic send_frame(input logic [1:0] t, input logic z, input logic [1:0] n,
                              input logic [8:0] m);
        logic [13:0] f;
        f = {t, z, n, m};
        for (int i = 13; i >= 0; i--) send_bit(f[i], 1'b1);
    endtask

    task automatic pulse_ld();
        ser_ld = 1'b1;
        tick(5);
        ser_ld = 1'b0;
        tick(5);
    endtask

    task automatic chk_model(input string req);
        chk(req, {7'd0, eff_m}, {7'd0, mdl_sh[8:0]});
        chk(req, {14'd0, eff_n}, {14'd0, mdl_sh[10:9]});
        chk(req, {14'd0, eff_t}, {14'd0, mdl_sh[13:12]});
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        chk("R1", {7'd0, eff_m}, 16'h0019);
        chk("R1", {14'd0, eff_n}, 16'h0001);
        chk("R1", {14'd0, eff_t}, 16'h0000);
        chk("R1", {15'd0, test_out}, 16'h0000);

        // R2 parallel pass-through
        par_m = 9'h1A5; par_n = 2'b11;
        tick(2);
        chk("R2", {7'd0, eff_m}, 16'h01A5);
        chk("R2", {14'd0, eff_n}, 16'h0003);

        // R3 capture on rise of par_load_n
        par_load_n = 1'b1;
        tick(5);
        par_m = 9'h0F0; par_n = 2'b00;
        tick(5);
        chk("R3", {7'd0, eff_m}, 16'h01A5);
        chk("R3", {14'd0, eff_n}, 16'h0003);

        // R4 shifting with load low leaves outputs alone
        send_frame(2'b10, 1'b1, 2'b10, 9'h13B);
        tick(4);
        chk("R4", {7'd0, eff_m}, 16'h01A5);
        chk("R4", {14'd0, eff_t}, 16'h0000);

        // R5 frame order, R6 load rise transfer, R10 serial overrides parallel
        ser_ld = 1'b1;
        tick(5);
        chk("R5", {7'd0, eff_m}, 16'h013B);
        chk("R5", {14'd0, eff_n}, 16'h0002);
        chk("R5", {14'd0, eff_t}, 16'h0002);
        chk("R10", {7'd0, eff_m}, 16'h013B);
        ser_ld = 1'b0;
        tick(5);

        // R7 latched after load falls
        send_frame(2'b01, 1'b0, 2'b01, 9'h0A6);
        tick(4);
        chk("R7", {7'd0, eff_m}, 16'h013B);
        chk("R7", {14'd0, eff_t}, 16'h0002);

        // R6 transparency while load held high
        ser_ld = 1'b1;
        tick(5);
        chk_model("R6");
        send_bit(1'b1, 1'b1);
        tick(4);
        chk_model("R6");
        ser_ld = 1'b0;
        tick(5);

        // R8 test selector table, R5 frames with varied fields
        for (int i = 0; i < 8; i++) begin
            send_frame(VEC[i][5:4], i[0], i[1:0], 9'(i * 37));
            pulse_ld();
            chk_model("R5");
            fb_div_in = VEC[i][3];
            synth_clk_in = VEC[i][2];
            ser_dat = VEC[i][1];
            tick(1);
            chk("R8", {15'd0, test_out}, {15'd0, VEC[i][0]});
        end

        // R9 parallel mode forces test low, keeps T; R10 pins again
        synth_clk_in = 1'b1;
        par_m = 9'h055; par_n = 2'b10;
        par_load_n = 1'b0;
        tick(5);
        chk("R9", {15'd0, test_out}, 16'h0000);
        chk("R9", {14'd0, eff_t}, 16'h0003);
        chk("R10", {7'd0, eff_m}, 16'h0055);
        chk("R10", {14'd0, eff_n}, 16'h0002);

        // R11 strobe edges in parallel mode are ignored
        for (int i = 0; i < 14; i++) send_bit(1'b1, 1'b0);
        par_load_n = 1'b1;
        tick(5);
        chk("R3", {7'd0, eff_m}, 16'h0055);
        ser_ld = 1'b1;
        tick(5);
        chk_model("R11");
        ser_ld = 1'b0;
        tick(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule